// File: doc/BRIEF.md
# Two-Wire Slave for a Digital Potentiometer Register File

This block is the serial slave front end of a digitally controlled potentiometer. It watches SCL and SDA with an oversampling system clock, finds START and STOP conditions, and compares the first byte after a START with a seven-bit identity. That identity is a fixed five-bit prefix followed by two bits strapped on input pins. When the identity matches, the block takes a register pointer byte. After that it runs byte writes into the register file, or byte reads out of it, and handles the acknowledge bit of every byte.

The register file holds two registers. The wiper register sets the tap position and drives the `wiper_o` output. The control register has one read-only busy flag, which follows `wip_i` from the nonvolatile storage controller. While that flag is set, neither register accepts a write.

A typical read is a write-mode identity, then the pointer byte, then a repeated START, then a read-mode identity, then the data bytes. SDA is open-drain. The block only pulls the line low, through `sda_oe_o`.

Top module: `dcp_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. A STOP releases SDA and returns the slave to idle, and the slave then ignores all bytes until the next START.
- R2: Until the first START, the slave ignores the bus. A START that arrives within PWRUP_CYCLES clocks after reset is also ignored and gets no acknowledge.
- R3: Bytes travel most significant bit first. The slave samples SDA on a rising SCL and changes `sda_oe_o` only after a falling SCL.
- R4: The identity byte is `1010_0`, then A1 and A0 (`addr_pins_i[1]`, `addr_pins_i[0]`), then R/W (1 = read, 0 = write). A matching identity is acknowledged by holding SDA low for the ninth clock.
- R5: When the identity does not match, whether in the prefix or in the pin bits, the slave gives no acknowledge. It then stays idle and does not acknowledge any later byte until a new START.
- R6: The pointer byte is acknowledged, and so is every data byte of a write. Pointer 0x00 selects the wiper register and 0x02 selects the control register. The pointer does not advance, so consecutive data bytes all go to the same register.
- R7: A write to an unmapped pointer is acknowledged and discarded. A read from an unmapped pointer returns 0x00.
- R8: Bit 5 of the control register reads back as `wip_i`. While `wip_i` is 1, writes to the wiper register and to the control register have no effect.
- R9: In a read, the slave sends the selected register and keeps sending it while the master acknowledges. A master NACK makes the slave release SDA and wait for a START.
- R10: A repeated START, with no STOP before it, restarts identity matching while the pointer is kept.
- R11: After reset, `sda_oe_o` is 0, the wiper reads WIPER_RST (0x80), and the control register reads 0x00 apart from the busy flag.
- R12: Control-register bits other than bit 5 store the written value and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_pins_i | input | 2 | Strapped identity bits {A1, A0} |
| wip_i | input | 1 | Nonvolatile write in progress |
| wiper_o | output | 8 | Current wiper register value |

## Verification
Some properties are checked by assertions on every cycle:
- the line is released after every STOP;
- the FSM stays idle through the power-up window;
- SDA pull-down starts only after a falling SCL;
- the wiper holds still while busy is asserted.

Other behaviour only a bus scenario can show, so the bench runs those scenarios:
- identity matching against the strap pins;
- acknowledge and NACK patterns;
- MSB-first read data;
- the fixed pointer;
- unmapped addresses;
- masking of the busy bit in the control register.

// File: rtl/dcp_i2c_pkg.sv
package dcp_i2c_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ID, ST_ID_ACK, ST_REG, ST_REG_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_MACK, ST_RD_LOAD
  } bus_st_e;
  localparam logic [4:0] ID_PREFIX  = 5'b10100;
  localparam logic [7:0] PTR_WIPER  = 8'h00;
  localparam logic [7:0] PTR_CTRL   = 8'h02;
  localparam int         BUSY_BIT   = 5;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = SYNC_STAGES - 1;
  logic [LAST:0] scl_ff, sda_ff;
  logic          scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[LAST-1:0], scl_i};
      sda_ff <= {sda_ff[LAST-1:0], sda_i};
      scl_d  <= scl_ff[LAST];
      sda_d  <= sda_ff[LAST];
    end
  end

  assign sda_s_o    = sda_ff[LAST];
  assign scl_rise_o = scl_ff[LAST] & ~scl_d;
  assign scl_fall_o = ~scl_ff[LAST] & scl_d;
  // SDA edge while SCL high on both samples
  assign start_o    = scl_ff[LAST] & scl_d & sda_d & ~sda_ff[LAST];
  assign stop_o     = scl_ff[LAST] & scl_d & ~sda_d & sda_ff[LAST];
endmodule

// File: rtl/i2c_dcp_fsm.sv
module i2c_dcp_fsm
  import dcp_i2c_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_busy_i,
  input  logic [1:0] addr_pins_i,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic [7:0] ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o
);
  bus_st_e    st_q;
  logic [2:0] cnt_q;
  logic [7:0] sh_q, ptr_q;
  logic       rw_q, oe_q, wr_en_q;
  logic [7:0] rx_byte;

  assign rx_byte = {sh_q[6:0], sda_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i && !pwr_busy_i) begin
        st_q  <= ST_ID;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (scl_rise_i) begin
        case (st_q)
          ST_ID, ST_REG, ST_WR: begin
            sh_q  <= rx_byte;
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              if (st_q == ST_ID) begin
                if (rx_byte[7:1] == {ID_PREFIX, addr_pins_i}) begin
                  rw_q <= rx_byte[0];
                  st_q <= ST_ID_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (st_q == ST_REG) begin
                ptr_q <= rx_byte;
                st_q  <= ST_REG_ACK;
              end else begin
                wr_en_q <= 1'b1;
                st_q    <= ST_WR_ACK;
              end
            end
          end
          ST_RD: begin
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) st_q <= ST_RD_MACK;
          end
          ST_RD_MACK: st_q <= sda_s_i ? ST_IDLE : ST_RD_LOAD;
          default: ;
        endcase
      end else if (scl_fall_i) begin
        case (st_q)
          ST_ID_ACK, ST_REG_ACK, ST_WR_ACK: begin
            if (!oe_q) begin
              oe_q <= 1'b1;           // ninth clock: hold low
            end else begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              if (st_q == ST_ID_ACK && rw_q) begin
                sh_q <= rd_data_i;
                oe_q <= ~rd_data_i[7];
                st_q <= ST_RD;
              end else if (st_q == ST_ID_ACK) begin
                st_q <= ST_REG;
              end else begin
                st_q <= ST_WR;
              end
            end
          end
          ST_RD: begin
            sh_q <= {sh_q[6:0], 1'b0};
            oe_q <= ~sh_q[6];
          end
          ST_RD_MACK: oe_q <= 1'b0;
          ST_RD_LOAD: begin
            sh_q  <= rd_data_i;
            oe_q  <= ~rd_data_i[7];
            cnt_q <= '0;
            st_q  <= ST_RD;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_o     = ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = sh_q;

  assert_stop_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_q == ST_IDLE && !sda_oe_o));
  assert_pwrup_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_busy_i |-> st_q == ST_IDLE);
  assert_drive_after_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_i));
endmodule

// File: rtl/dcp_regs.sv
module dcp_regs
  import dcp_i2c_pkg::*;
#(
  parameter logic [7:0] WIPER_RST = 8'h80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] ptr_i,
  input  logic [7:0] wr_data_i,
  input  logic       wip_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] wiper_o
);
  localparam logic [7:0] BUSY_MASK = 8'(1 << BUSY_BIT);
  logic [7:0] wiper_q, ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_q <= WIPER_RST;
      ctrl_q  <= '0;
    end else if (wr_en_i && !wip_i) begin
      if (ptr_i == PTR_WIPER) wiper_q <= wr_data_i;
      if (ptr_i == PTR_CTRL)  ctrl_q  <= wr_data_i & ~BUSY_MASK;
    end
  end

  always_comb begin
    case (ptr_i)
      PTR_WIPER: rd_data_o = wiper_q;
      PTR_CTRL:  rd_data_o = (ctrl_q & ~BUSY_MASK) | (wip_i ? BUSY_MASK : 8'h00);
      default:   rd_data_o = 8'h00;
    endcase
  end

  assign wiper_o = wiper_q;

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_i |=> $stable(wiper_o));
endmodule

// File: rtl/dcp_i2c_slave.sv
module dcp_i2c_slave #(
  parameter int         PWRUP_CYCLES = 256,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] WIPER_RST    = 8'h80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] addr_pins_i,
  input  logic       wip_i,
  output logic [7:0] wiper_o
);
  localparam int PW = $clog2(PWRUP_CYCLES + 1);

  logic [PW-1:0] pwr_cnt_q;
  logic          pwr_busy;
  logic          sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [7:0]    ptr, wr_data, rd_data;
  logic          wr_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pwr_cnt_q <= '0;
    else if (pwr_busy) pwr_cnt_q <= pwr_cnt_q + 1'b1;
  end
  assign pwr_busy = (pwr_cnt_q != PW'(PWRUP_CYCLES));

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2c_dcp_fsm u_fsm (
    .clk_i, .rst_ni,
    .pwr_busy_i(pwr_busy), .addr_pins_i,
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c), .rd_data_i(rd_data),
    .sda_oe_o, .ptr_o(ptr), .wr_en_o(wr_en), .wr_data_o(wr_data)
  );

  dcp_regs #(.WIPER_RST(WIPER_RST)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .ptr_i(ptr), .wr_data_i(wr_data), .wip_i,
    .rd_data_o(rd_data), .wiper_o
  );
endmodule

// File: tb/dcp_i2c_slave_tb_top.sv
module dcp_i2c_slave_tb_top;
  localparam int QP = 8;
  localparam logic [1:0] PINS = 2'b01;
  localparam logic [7:0] ID_W = {5'b10100, PINS, 1'b0};
  localparam logic [7:0] ID_R = {5'b10100, PINS, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, wip = 1'b0;
  logic sda_oe;
  logic [7:0] wiper;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  dcp_i2c_slave #(.PWRUP_CYCLES(64)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_pins_i(PINS), .wip_i(wip), .wiper_o(wiper)
  );

  typedef struct { string req; logic [7:0] val; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic push(input string req, input logic [7:0] v);
    exp_t e; e.req = req; e.val = v; exp_q.push_back(e);
  endtask

  // monitor side of the scoreboard
  task automatic observe(input logic [7:0] act);
    exp_t e;
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %02h expected none", act);
    end else begin
      e = exp_q.pop_front();
      chk(e.req, act, e.val);
    end
  endtask

  task automatic half(); repeat (QP) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; half(); scl = 1'b1; half(); sda_m = 1'b0; half(); scl = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half(); scl = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic wr_byte(input logic [7:0] b);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl = 1'b1; half(); scl = 1'b0;
    end
    sda_m = 1'b1; half(); scl = 1'b1; half(); ack = sda_bus; scl = 1'b0; half();
    observe({7'd0, ack});
  endtask

  task automatic rd_byte(input logic mack);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half(); scl = 1'b1; half(); b[i] = sda_bus; scl = 1'b0;
    end
    observe(b);
    sda_m = ~mack; half(); scl = 1'b1; half(); scl = 1'b0; half(); sda_m = 1'b1;
  endtask

  task automatic reg_write(input logic [7:0] ra, input logic [7:0] d);
    bus_start();
    push("R4", 8'h00); wr_byte(ID_W);
    push("R6", 8'h00); wr_byte(ra);
    push("R6", 8'h00); wr_byte(d);
    bus_stop(); half();
  endtask

  task automatic reg_read(input string req, input logic [7:0] ra, input logic [7:0] exp);
    bus_start();
    push("R4", 8'h00); wr_byte(ID_W);
    push("R6", 8'h00); wr_byte(ra);
    bus_start();
    push("R10", 8'h00); wr_byte(ID_R);
    push(req, exp); rd_byte(1'b1);
    push("R9", exp); rd_byte(1'b0);
    bus_stop(); half();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 oe", {7'd0, sda_oe}, 8'h00);
    chk("R11 wiper", wiper, 8'h80);
    rst_n = 1'b1;
    // START inside power-up window
    bus_start();
    push("R2", 8'h01); wr_byte(ID_W);
    bus_stop();
    repeat (100) @(negedge clk);
    reg_read("R11", 8'h02, 8'h00);
    reg_write(8'h00, 8'h3C);
    chk("R6 wiper", wiper, 8'h3C);
    reg_read("R3", 8'h00, 8'h3C);
    // wrong prefix, then wrong pin bits
    bus_start();
    push("R5", 8'h01); wr_byte(8'hB2);
    push("R5", 8'h01); wr_byte(8'h00);
    bus_stop(); half();
    bus_start();
    push("R5", 8'h01); wr_byte({5'b10100, 2'b10, 1'b0});
    bus_stop(); half();
    chk("R5 wiper", wiper, 8'h3C);
    // busy pulse from storage controller model
    wip = 1'b1;
    reg_write(8'h00, 8'h11);
    chk("R8 wiper", wiper, 8'h3C);
    reg_write(8'h02, 8'h0F);
    reg_read("R8", 8'h02, 8'h20);
    wip = 1'b0;
    reg_read("R8", 8'h02, 8'h00);
    reg_write(8'h02, 8'hFF);
    reg_read("R12", 8'h02, 8'hDF);
    // unmapped pointer
    reg_write(8'h05, 8'h77);
    reg_read("R7", 8'h05, 8'h00);
    chk("R7 wiper", wiper, 8'h3C);
    // two data bytes, same pointer
    bus_start();
    push("R4", 8'h00); wr_byte(ID_W);
    push("R6", 8'h00); wr_byte(8'h00);
    push("R6", 8'h00); wr_byte(8'h10);
    push("R6", 8'h00); wr_byte(8'h20);
    bus_stop(); half();
    chk("R6 no advance", wiper, 8'h20);
    reg_read("R6", 8'h02, 8'hDF);
    // STOP mid-transaction
    bus_start();
    push("R4", 8'h00); wr_byte(ID_W);
    bus_stop(); half();
    chk("R1 oe", {7'd0, sda_oe}, 8'h00);
    push("R1", 8'h01); wr_byte(8'h00);
    chk("R1 wiper", wiper, 8'h20);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule